// File: doc/BRIEF.md
# Gated Period Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that runs in a fixed period. A prescaler divides the timer clock. The counter advances on each prescaled tick while a software run bit is set. When the count equals a programmed period value, the next tick returns it to zero. Each such wrap is a period match. Matches feed a postscaler, which emits a one-cycle event pulse once every N matches. The same pulse sets a sticky flag, which holds until it is explicitly cleared.

The run bit and the external clear are written from outside the timer clock domain. Each passes through a two-stage synchroniser before it acts. The period, the scaler selects and the mode field are static configuration, read directly. Only the software-gated free-running mode is implemented. Any other mode value parks the counter.

Top module: `prd_timer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count, event pulse, sticky flag, synchronisers and both scaler counters are cleared to 0.
- R2: The counter can advance only when `mode` equals 5'b00000. With any other value the count holds. Counting resumes on the next tick once `mode` returns to 5'b00000.
- R3: While the run bit is active, the count rises by exactly one on each prescaled tick. While the run bit is inactive, the count holds its value.
- R4: A tick that finds the count equal to `period` loads 0 instead of incrementing. With period 5 the count runs 0,1,2,3,4,5,0,1. With period 0 the count stays at 0 and every tick is a match.
- R5: A change on `run_en` first affects counting on the third rising edge after it is applied. The two edges before that still use the old value.
- R6: `pre_sel` = k divides the timer clock by 2^k, for k from 0 to 7. One tick is issued for every 2^k enabled cycles, counted from a cleared prescaler.
- R7: `post_sel` = v raises `evt_pulse` on every (v+1)-th period match, for v from 0 to 15. The pulse lasts one cycle: the cycle in which the count shows the 0 that the wrap loaded.
- R8: `ext_clr` reaches the counter with the same three-edge latency as `run_en`. While it is active, it forces the count, the prescaler counter and the postscaler counter to 0, ahead of counting.
- R9: `evt_flag` sets together with each `evt_pulse` and holds until `flag_clr` is high at a rising edge. If a pulse and a clear arrive on the same edge, the flag stays set.
- R10: When the run bit drops, the prescaler and postscaler counters freeze at their current values. When the run bit returns, they continue from those values without restarting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Software run bit, asynchronous to `clk` |
| ext_clr | input | 1 | External clear request, asynchronous to `clk` |
| mode | input | 5 | Operating mode; only 5'b00000 counts |
| period | input | 8 | Period value at which the count wraps |
| pre_sel | input | 3 | Prescaler select, divide by 2^pre_sel |
| post_sel | input | 4 | Postscaler select, one pulse per post_sel+1 matches |
| flag_clr | input | 1 | Clears the sticky flag |
| count | output | 8 | Current count |
| evt_pulse | output | 1 | One-cycle postscaled match pulse |
| evt_flag | output | 1 | Sticky match flag |

## Verification
Two pairs of events can land on the same clock edge.

The first pair is a postscaled match and a `flag_clr` on the same edge. The bench raises `flag_clr` in the cycle where the count sits at the period value. It then expects the flag still set, with the pulse present.

The second pair is the external clear and pending scaler progress. The bench lets the clear land while the prescaler and postscaler hold partial counts. It then counts the enabled cycles up to the next tick and the matches up to the next pulse after release. Partial counts that had survived the clear would shorten both intervals.

// File: rtl/pt_pkg.sv
// Shared constants and types for the gated period timer.
// Assumes a single timer clock domain for everything downstream of the synchroniser.
package pt_pkg;

    // Mode code that selects software-gated free-running operation
    localparam logic [4:0] MODE_SWGATE = 5'b00000;

    // Asynchronous controls carried together through the synchroniser
    typedef struct packed {
        logic run;
        logic clr;
    } pt_ctrl_t;

endpackage

// File: rtl/pt_sync.sv
// Multi-bit flop-chain synchroniser for level-type control inputs.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module pt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            // Single capture stage
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= d;
            end
        end else begin : g_chain
            // Shift the input through the stage chain
            always_ff @(posedge clk) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/pt_prescale.sv
// Power-of-two clock prescaler producing single-cycle count ticks.
// Assumes en is already gated by run, mode and clear; clr has priority.
// The counter holds its value when en is low (freeze, not restart).
module pt_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    localparam int DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] limit;

    // Terminal value is 2^sel - 1
    always_comb limit = ~({DIV_W{1'b1}} << sel);

    // Tick on the terminal count; >= keeps a select change from stranding the counter
    always_comb tick = en && (div_cnt >= limit);

    // Advance, restart on tick, freeze when disabled, clear on request
    always_ff @(posedge clk) begin
        if (!rst_n || clr) div_cnt <= '0;
        else if (tick)     div_cnt <= '0;
        else if (en)       div_cnt <= div_cnt + 1'b1;
    end

    assert_tick_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_cnt == '0));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(div_cnt));

endmodule

// File: rtl/pt_postscale.sv
// Match-event divider: fires on every (sel+1)-th match.
// Assumes match is only asserted on an enabled tick; clr has priority.
module pt_postscale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             match,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);

    logic [SEL_W-1:0] ev_cnt;

    // Fire on the match that completes the programmed group
    always_comb fire = match && (ev_cnt >= sel);

    // Count matches, restart after firing, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ev_cnt <= '0;
        else if (fire)     ev_cnt <= '0;
        else if (match)    ev_cnt <= ev_cnt + 1'b1;
    end

    assert_fire_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (ev_cnt == '0));

    assert_hold_no_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !clr) |=> $stable(ev_cnt));

endmodule

// File: rtl/prd_timer.sv
// Gated period timer: synchronised run/clear, prescaled up-counter with
// wrap-after-equal, postscaled event pulse and sticky flag.
// Assumes period, pre_sel, post_sel and mode are quasi-static in the clk domain.
module prd_timer
    import pt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PSEL_W      = 3,
    parameter int QSEL_W      = 4,
    parameter int MODE_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              ext_clr,
    input  logic [MODE_W-1:0] mode,
    input  logic [CNT_W-1:0]  period,
    input  logic [PSEL_W-1:0] pre_sel,
    input  logic [QSEL_W-1:0] post_sel,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  count,
    output logic              evt_pulse,
    output logic              evt_flag
);

    localparam int CTRL_W = $bits(pt_ctrl_t);

    pt_ctrl_t ctrl_raw;
    pt_ctrl_t ctrl_s;
    logic     mode_ok;
    logic     cnt_en;
    logic     pre_tick;
    logic     at_top;
    logic     match;
    logic     post_fire;

    // Bundle the asynchronous controls
    always_comb begin
        ctrl_raw.run = run_en;
        ctrl_raw.clr = ext_clr;
    end

    pt_sync #(
        .WIDTH  (CTRL_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ctrl_raw),
        .q     (ctrl_s)
    );

    // Counting qualifier: run bit, supported mode, no clear in progress
    always_comb begin
        mode_ok = (mode == MODE_W'(MODE_SWGATE));
        cnt_en  = ctrl_s.run && mode_ok && !ctrl_s.clr;
    end

    pt_prescale #(
        .SEL_W (PSEL_W)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_s.clr),
        .en    (cnt_en),
        .sel   (pre_sel),
        .tick  (pre_tick)
    );

    // Period match: a tick that finds the count at the period value
    always_comb begin
        at_top = (count == period);
        match  = pre_tick && at_top;
    end

    pt_postscale #(
        .SEL_W (QSEL_W)
    ) u_post (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctrl_s.clr),
        .match (match),
        .sel   (post_sel),
        .fire  (post_fire)
    );

    // Main counter: clear first, then wrap-after-equal or increment on tick
    always_ff @(posedge clk) begin
        if (!rst_n || ctrl_s.clr) count <= '0;
        else if (match)           count <= '0;
        else if (pre_tick)        count <= count + 1'b1;
    end

    // Register the postscaled event as a one-cycle pulse
    always_ff @(posedge clk) begin
        if (!rst_n) evt_pulse <= 1'b0;
        else        evt_pulse <= post_fire;
    end

    // Sticky flag: a new event wins over a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n)         evt_flag <= 1'b0;
        else if (post_fire) evt_flag <= 1'b1;
        else if (flag_clr)  evt_flag <= 1'b0;
    end

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && at_top && !ctrl_s.clr) |=> (count == '0));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_s.run && !ctrl_s.clr) |=> $stable(count));

    assert_mode_park_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_ok && !ctrl_s.clr) |=> $stable(count));

    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_s.clr |=> (count == '0));

    assert_pulse_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> (count == '0));

    assert_flag_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |-> evt_flag);

endmodule

// File: tb/prd_timer_tb.sv
// Directed bench for prd_timer: one task per scenario, checks at negedge.
module prd_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic       ext_clr;
    logic [4:0] mode;
    logic [7:0] period;
    logic [2:0] pre_sel;
    logic [3:0] post_sel;
    logic       flag_clr;
    logic [7:0] count;
    logic       evt_pulse;
    logic       evt_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc++;

    prd_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ext_clr   (ext_clr),
        .mode      (mode),
        .period    (period),
        .pre_sel   (pre_sel),
        .post_sel  (post_sel),
        .flag_clr  (flag_clr),
        .count     (count),
        .evt_pulse (evt_pulse),
        .evt_flag  (evt_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        run_en   = 1'b0;
        ext_clr  = 1'b0;
        mode     = 5'b00000;
        period   = 8'd5;
        pre_sel  = 3'd0;
        post_sel = 4'd0;
        flag_clr = 1'b0;
        step(3);
        rst_n = 1'b1;
    endtask

    // R1: state right after reset
    task automatic t_reset_state();
        do_reset();
        chk("R1", "count after reset", count, 0);
        chk("R1", "pulse after reset", evt_pulse, 0);
        chk("R1", "flag after reset", evt_flag, 0);
    endtask

    // R4/R5/R7: period 5 sequence and enable latency
    task automatic t_wrap_p5();
        do_reset();
        run_en = 1'b1;
        step(2);
        chk("R5", "count before sync latency ends", count, 0);
        for (int k = 1; k <= 14; k++) begin
            step(1);
            chk("R4", "period5 count", count, k % 6);
            chk("R7", "period5 pulse", evt_pulse, (k % 6 == 0) ? 1 : 0);
        end
    endtask

    // R3/R5: disable latency and hold
    task automatic t_disable();
        do_reset();
        period = 8'd200;
        run_en = 1'b1;
        step(12);
        chk("R3", "count after 10 ticks", count, 10);
        run_en = 1'b0;
        step(2);
        chk("R5", "count during disable latency", count, 12);
        step(6);
        chk("R3", "count held while disabled", count, 12);
        run_en = 1'b1;
        step(2);
        chk("R5", "count during enable latency", count, 12);
        step(1);
        chk("R3", "count resumes", count, 13);
    endtask

    // R6/R10: divide by 4, freeze and resume of prescaler
    task automatic t_prescale();
        do_reset();
        period  = 8'd200;
        pre_sel = 3'd2;
        run_en  = 1'b1;
        step(2);
        for (int m = 1; m <= 13; m++) begin
            step(1);
            chk("R6", "div4 count", count, m / 4);
        end
        run_en = 1'b0;
        step(10);
        chk("R10", "count frozen", count, 3);
        run_en = 1'b1;
        step(2);
        chk("R10", "count before resume", count, 3);
        step(1);
        chk("R10", "prescaler resumed from held phase", count, 4);
        // largest ratio, 1:128
        do_reset();
        period  = 8'd200;
        pre_sel = 3'd7;
        run_en  = 1'b1;
        step(2 + 127);
        chk("R6", "div128 before tick", count, 0);
        step(1);
        chk("R6", "div128 first tick", count, 1);
    endtask

    // R7/R4: postscaler ratios including period 0 and ratio 16
    task automatic t_postscale();
        do_reset();
        period   = 8'd2;
        post_sel = 4'd2;
        run_en   = 1'b1;
        step(2);
        for (int m = 1; m <= 20; m++) begin
            step(1);
            chk("R7", "ratio3 pulse", evt_pulse, (m % 9 == 0) ? 1 : 0);
            chk("R9", "ratio3 flag", evt_flag, (m >= 9) ? 1 : 0);
        end
        do_reset();
        period   = 8'd0;
        post_sel = 4'd15;
        run_en   = 1'b1;
        step(2);
        for (int m = 1; m <= 32; m++) begin
            step(1);
            chk("R4", "period0 count", count, 0);
            chk("R7", "ratio16 pulse", evt_pulse, (m % 16 == 0) ? 1 : 0);
        end
    endtask

    // R8: external clear latency, priority, scaler clearing
    task automatic t_ext_clear();
        do_reset();
        period  = 8'd200;
        pre_sel = 3'd2;
        run_en  = 1'b1;
        step(2 + 9);
        chk("R8", "count before clear", count, 2);
        ext_clr = 1'b1;
        step(2);
        chk("R8", "count during clear latency", count, 2);
        step(1);
        chk("R8", "count cleared", count, 0);
        step(5);
        chk("R8", "clear holds over counting", count, 0);
        ext_clr = 1'b0;
        step(2);
        chk("R8", "count during release latency", count, 0);
        step(3);
        chk("R8", "prescaler restarted (no early tick)", count, 0);
        step(1);
        chk("R8", "first tick after full division", count, 1);
        // postscaler phase is cleared
        do_reset();
        period   = 8'd3;
        post_sel = 4'd1;
        run_en   = 1'b1;
        step(2 + 4);
        ext_clr = 1'b1;
        step(3);
        ext_clr = 1'b0;
        step(2);
        for (int m = 1; m <= 8; m++) begin
            step(1);
            chk("R8", "postscaler restarted pulse", evt_pulse, (m == 8) ? 1 : 0);
        end
    endtask

    // R9/R1: sticky flag, clear, set-wins collision, reset
    task automatic t_flag();
        do_reset();
        run_en = 1'b1;
        step(2 + 6);
        chk("R9", "flag set with pulse", evt_flag, 1);
        step(3);
        chk("R9", "flag sticky", evt_flag, 1);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R9", "flag cleared", evt_flag, 0);
        step(1);
        chk("R4", "count at period", count, 5);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R9", "collision pulse", evt_pulse, 1);
        chk("R9", "collision flag stays set", evt_flag, 1);
        step(1);
        chk("R9", "flag after collision", evt_flag, 1);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk("R1", "flag cleared by reset", evt_flag, 0);
        chk("R1", "count cleared by reset", count, 0);
    endtask

    // R2: unsupported modes park the counter
    task automatic t_mode();
        do_reset();
        period = 8'd200;
        mode   = 5'b00011;
        run_en = 1'b1;
        step(10);
        chk("R2", "count parked in mode 00011", count, 0);
        mode = 5'b00000;
        step(1);
        chk("R2", "count resumes in mode 00000", count, 1);
        step(2);
        chk("R2", "count advancing", count, 3);
        mode = 5'b10000;
        step(5);
        chk("R2", "count parked in mode 10000", count, 3);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        summary();
    end

    initial begin
        t_reset_state();
        t_wrap_p5();
        t_disable();
        t_prescale();
        t_postscale();
        t_ext_clear();
        t_flag();
        t_mode();
        summary();
    end

endmodule